// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a CAN bit sampler that has already removed the stuff bits. For every frame bit it receives the bit value and that bit's position in the frame, where position 0 is the start-of-frame bit. It pulls out the identifier, control, data, CRC and acknowledge fields. Both the 11-bit identifier layout and the 29-bit identifier layout are handled.

The field positions are fixed up to the length code. Past that point the parser computes where the data field ends, from the identifier layout, the remote-request bit and the length code. It finds the CRC, both delimiters, the acknowledge slot and the end of frame at fixed distances from that end-of-data position.

While the frame arrives, a CRC-15 is accumulated over the frame and then compared with the CRC received on the bus. When the last end-of-frame bit is accepted, every field is copied into output registers and `frame_done` pulses for one cycle. That pulse also tells the sampler the frame is over, and the parser clears itself for the next frame.

Top module: `can_field_parser`

## Requirements
- R1: After reset, `frame_done` is 0 and every field output, flag and identifier reads 0.
- R2: 11-bit identifier frame. Positions 1..11 give `base_id`, MSB first. Position 12 is the remote-request bit. Position 13 is 0 and selects this layout (`ext_frame`=0). Position 14 is `rsv[0]`, and `rsv[1]` stays 0. Positions 15..18 give `dlc`, MSB first.
- R3: 29-bit identifier frame (position 13 = 1, so `ext_frame`=1). Position 12 is `srr`. Positions 14..31 give `ext_id`, MSB first. Position 32 is the remote-request bit. Positions 33 and 34 are `rsv[1]` and `rsv[0]`. Positions 35..38 give `dlc`. `full_id` = `base_id`<<18 | `ext_id`. In the 11-bit layout, `full_id` = `base_id`, and `ext_id` and `srr` read 0.
- R4: Call the last length-code position E (18 or 38). Data byte k occupies positions E+1+8k..E+8+8k, MSB first, and appears on `data[8k+7:8k]`. Bytes beyond the length read 0.
- R5: A `dlc` value of 9..15 carries 8 data bytes. The `dlc` output reports the raw received code.
- R6: When the remote-request bit is 1, the frame carries no data, `data` reads 0, and the CRC starts at position E+1 whatever `dlc` is.
- R7: Let L be the last data position. `crc_rx` is positions L+1..L+15, MSB first. `crc_ok`=1 exactly when `crc_rx` equals the CRC-15 computed over positions 0..L. That CRC starts from 0 and uses polynomial 0x4599. Each step shifts left and XORs in the polynomial when the incoming bit differs from the old MSB.
- R8: `ack_ok` is 1 when position L+17 is 0 (dominant), and 0 when it is 1.
- R9: `form_err` is 1 when the CRC delimiter (L+16) or the acknowledge delimiter (L+18) is 0.
- R10: `sof_err` is 1 when position 0 is 1 (recessive).
- R11: `frame_done` is high for exactly the one cycle after position L+25 is accepted. The outputs change only at that edge and hold until the next frame. The following frame is then parsed from a clean state.
- R12: Cycles with `bit_valid`=0 are ignored, whatever `bit_value` and `bit_index` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | One destuffed frame bit is offered this cycle |
| bit_value | input | 1 | Bit level, 0 = dominant |
| bit_index | input | 7 | Position of the bit in the frame, 0 = start of frame |
| frame_done | output | 1 | One-cycle pulse: frame complete, fields valid |
| ext_frame | output | 1 | 29-bit identifier layout |
| rtr | output | 1 | Remote-request bit of the frame |
| srr | output | 1 | Substitute remote bit (29-bit layout only) |
| rsv | output | 2 | Reserved bits {r1, r0} |
| dlc | output | 4 | Received length code |
| base_id | output | 11 | 11-bit base identifier |
| ext_id | output | 18 | 18-bit identifier extension |
| full_id | output | 29 | Complete identifier |
| data | output | 64 | Data bytes, byte k on bits 8k+7..8k |
| crc_rx | output | 15 | Received CRC |
| crc_ok | output | 1 | Received CRC matches the computed one |
| ack_ok | output | 1 | Acknowledge slot was dominant |
| sof_err | output | 1 | Start-of-frame bit was recessive |
| form_err | output | 1 | A delimiter was dominant |

## Verification
The assertions check the following on every cycle:
- `frame_done` is a single-cycle pulse that only follows an accepted bit.
- The outputs hold steady between pulses.
- Remote frames and short frames leave the unused data bytes at zero.
- The 11-bit layout never shows extension fields.

Only the bench's scenarios can show that each field lands in the right place and that the CRC verdict matches arithmetic done outside the design. The scenarios sweep every length code in both layouts, including 9..15, and include remote frames. They also inject single faults: a flipped CRC, a missing acknowledge, dominant delimiters and a recessive start bit. Between bits the bench drives misleading indices and levels while `bit_valid` is low.

// File: rtl/can_fp_pkg.sv
// Package: widths, fixed frame positions and the CRC-15 step shared by the
// parser modules. Positions are counted on destuffed bits, 0 = start of frame.
package can_fp_pkg;
    localparam int IDX_W     = 7;
    localparam int POS_W     = IDX_W + 1;      // one spare bit so L+25 never wraps
    localparam int BASE_W    = 11;
    localparam int EXT_W     = 18;
    localparam int ID_W      = BASE_W + EXT_W;
    localparam int DLC_W     = 4;
    localparam int CRC_W     = 15;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * 8;
    localparam int DPOS_W    = $clog2(DATA_W);
    localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

    typedef logic [POS_W-1:0] pos_t;

    // fixed positions in the control part of the frame
    localparam pos_t P_BASE_END    = pos_t'(BASE_W);
    localparam pos_t P_BIT12       = pos_t'(12);
    localparam pos_t P_IDE         = pos_t'(13);
    localparam pos_t P_STD_R0      = pos_t'(14);
    localparam pos_t P_STD_DLC_END = pos_t'(18);
    localparam pos_t P_EXT_ID_END  = pos_t'(31);
    localparam pos_t P_EXT_RTR     = pos_t'(32);
    localparam pos_t P_EXT_R1      = pos_t'(33);
    localparam pos_t P_EXT_R0      = pos_t'(34);
    localparam pos_t P_EXT_DLC_END = pos_t'(38);

    // offsets from the last data position
    localparam pos_t OFS_CRC_END = pos_t'(15);
    localparam pos_t OFS_CRC_DEL = pos_t'(16);
    localparam pos_t OFS_ACK     = pos_t'(17);
    localparam pos_t OFS_ACK_DEL = pos_t'(18);
    localparam pos_t OFS_EOF     = pos_t'(25);

    // Working and output field set of one frame.
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [EXT_W-1:0]  ext_id;
        logic              bit12;
        logic              ide;
        logic              rtr_x;
        logic              r1;
        logic              r0;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic [CRC_W-1:0]  crc_rx;
        logic              ack_ok;
        logic              sof_err;
        logic              form_err;
    } fields_t;

    // One serial CRC-15 step: shift left, fold in the polynomial on mismatch.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
        logic fold;
        fold = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fold ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/can_fp_crc.sv
// Serial CRC-15 accumulator.
// Assumes: start marks the first frame bit and restarts from zero; en marks
// every later bit that belongs to the protected range; clr wins over both.
module can_fp_crc
    import can_fp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    // Purpose: fold each protected bit into the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= '0;
        end else if (start) begin
            crc <= crc_step('0, din);
        end else if (en) begin
            crc <= crc_step(crc, din);
        end
    end
endmodule

// File: rtl/can_fp_layout.sv
// Frame layout calculator: the last length-code position and the last data
// position. Pure combinational.
// Assumes: ext, rtr and dlc are final once the bit index passes the
// length code; earlier values only give positions the parser does not use.
module can_fp_layout
    import can_fp_pkg::*;
(
    input  logic             ext,
    input  logic             rtr,
    input  logic [DLC_W-1:0] dlc,
    output pos_t             dlc_end,
    output pos_t             last_data
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    logic [CNT_W-1:0] nbytes;

    // Purpose: clamp the length code and drop data for remote frames.
    always_comb begin
        if (rtr)
            nbytes = '0;
        else if (int'(dlc) > MAX_BYTES)
            nbytes = CNT_W'(MAX_BYTES);
        else
            nbytes = CNT_W'(dlc);
        dlc_end   = ext ? P_EXT_DLC_END : P_STD_DLC_END;
        last_data = dlc_end + pos_t'({nbytes, 3'b000});
    end
endmodule

// File: rtl/can_field_parser.sv
// CAN frame field parser (top).
// Takes destuffed frame bits with their position and builds the fields in a
// working set. On the last end-of-frame bit it copies the set to the outputs,
// pulses frame_done, and clears the working set.
// Assumes: positions arrive in increasing order, each once, starting at 0. A
// bit at position 0 always restarts parsing, so an abandoned frame is dropped.
module can_field_parser
    import can_fp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_value,
    input  logic [IDX_W-1:0]  bit_index,
    output logic              frame_done,
    output logic              ext_frame,
    output logic              rtr,
    output logic              srr,
    output logic [1:0]        rsv,
    output logic [DLC_W-1:0]  dlc,
    output logic [BASE_W-1:0] base_id,
    output logic [EXT_W-1:0]  ext_id,
    output logic [ID_W-1:0]   full_id,
    output logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_rx,
    output logic              crc_ok,
    output logic              ack_ok,
    output logic              sof_err,
    output logic              form_err
);
    fields_t          w;          // fields of the frame in flight
    fields_t          o;          // fields of the last completed frame
    logic             o_crc_ok;
    pos_t             idx;
    pos_t             dlc_end;
    pos_t             last_data;
    logic             rtr_now;
    logic             is_start;
    logic             in_data;
    logic             in_crc;
    logic             done_now;
    logic [DPOS_W-1:0] data_off;
    logic [DPOS_W-1:0] data_pos;
    logic [CRC_W-1:0] crc_calc;

    assign idx     = pos_t'(bit_index);
    assign rtr_now = w.ide ? w.rtr_x : w.bit12;

    can_fp_layout u_layout (
        .ext       (w.ide),
        .rtr       (rtr_now),
        .dlc       (w.dlc),
        .dlc_end   (dlc_end),
        .last_data (last_data)
    );

    // Purpose: classify the offered bit against the current layout.
    always_comb begin
        is_start = bit_valid && (idx == '0);
        in_data  = (idx > dlc_end) && (idx <= last_data);
        in_crc   = (idx > last_data) && (idx <= last_data + OFS_CRC_END);
        done_now = bit_valid && (idx == last_data + OFS_EOF);
        data_off = DPOS_W'(idx - dlc_end - pos_t'(1));
        data_pos = {data_off[DPOS_W-1:3], ~data_off[2:0]};
    end

    can_fp_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (done_now),
        .start (is_start),
        .en    (bit_valid && (idx <= last_data)),
        .din   (bit_value),
        .crc   (crc_calc)
    );

    // Purpose: place each accepted bit into its field of the working set.
    always_ff @(posedge clk) begin
        if (!rst_n || done_now) begin
            w <= '0;
        end else if (bit_valid) begin
            if (idx == '0) begin
                w         <= '0;
                w.sof_err <= bit_value;
            end else if (idx <= P_BASE_END) begin
                w.base <= {w.base[BASE_W-2:0], bit_value};
            end else if (idx == P_BIT12) begin
                w.bit12 <= bit_value;
            end else if (idx == P_IDE) begin
                w.ide <= bit_value;
            end else if (idx <= dlc_end) begin
                if (!w.ide) begin
                    if (idx == P_STD_R0) w.r0 <= bit_value;
                    else                 w.dlc <= {w.dlc[DLC_W-2:0], bit_value};
                end else begin
                    if (idx <= P_EXT_ID_END)   w.ext_id <= {w.ext_id[EXT_W-2:0], bit_value};
                    else if (idx == P_EXT_RTR) w.rtr_x <= bit_value;
                    else if (idx == P_EXT_R1)  w.r1 <= bit_value;
                    else if (idx == P_EXT_R0)  w.r0 <= bit_value;
                    else                       w.dlc <= {w.dlc[DLC_W-2:0], bit_value};
                end
            end else if (in_data) begin
                w.data[data_pos] <= bit_value;
            end else if (in_crc) begin
                w.crc_rx <= {w.crc_rx[CRC_W-2:0], bit_value};
            end else if (idx == last_data + OFS_CRC_DEL || idx == last_data + OFS_ACK_DEL) begin
                w.form_err <= w.form_err | ~bit_value;
            end else if (idx == last_data + OFS_ACK) begin
                w.ack_ok <= ~bit_value;
            end
        end
    end

    // Purpose: publish the completed frame and raise the one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o          <= '0;
            o_crc_ok   <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= done_now;
            if (done_now) begin
                o        <= w;
                o_crc_ok <= (crc_calc == w.crc_rx);
            end
        end
    end

    assign ext_frame = o.ide;
    assign rtr       = o.ide ? o.rtr_x : o.bit12;
    assign srr       = o.ide & o.bit12;
    assign rsv       = {o.r1, o.r0};
    assign dlc       = o.dlc;
    assign base_id   = o.base;
    assign ext_id    = o.ext_id;
    assign full_id   = o.ide ? {o.base, o.ext_id} : {{EXT_W{1'b0}}, o.base};
    assign data      = o.data;
    assign crc_rx    = o.crc_rx;
    assign crc_ok    = o_crc_ok;
    assign ack_ok    = o.ack_ok;
    assign sof_err   = o.sof_err;
    assign form_err  = o.form_err;
endmodule

// File: rtl/can_fp_checker.sv
// Property checker for can_field_parser, attached by bind below.
// Assumes the parser's port names; observes only, drives nothing.
module can_fp_checker
    import can_fp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_valid,
    input logic              frame_done,
    input logic              ext_frame,
    input logic              rtr,
    input logic              srr,
    input logic [1:0]        rsv,
    input logic [DLC_W-1:0]  dlc,
    input logic [BASE_W-1:0] base_id,
    input logic [EXT_W-1:0]  ext_id,
    input logic [DATA_W-1:0] data,
    input logic              crc_ok
);
    // R11: the completion pulse lasts one cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R12: a cycle without an offered bit cannot complete a frame
    a_r12_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> !frame_done);

    // R11: published fields hold between completions
    a_r11_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> ($stable(dlc) && $stable(data) && $stable(crc_ok)
                         && $stable(base_id) && $stable(ext_id)));

    // R6: remote frames publish no data
    a_r6_remote_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rtr) |-> (data == '0));

    // R4: bytes past a short length code stay zero
    a_r4_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !rtr && dlc < 4'd8) |-> ((data >> {dlc[2:0], 3'b000}) == '0));

    // R3: the 11-bit layout shows no extension fields
    a_r3_std_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_frame |-> (ext_id == '0 && !srr && !rsv[1]));
endmodule

bind can_field_parser can_fp_checker u_can_fp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .frame_done (frame_done),
    .ext_frame  (ext_frame),
    .rtr        (rtr),
    .srr        (srr),
    .rsv        (rsv),
    .dlc        (dlc),
    .base_id    (base_id),
    .ext_id     (ext_id),
    .data       (data),
    .crc_ok     (crc_ok)
);

// File: tb/tb_can_field_parser.sv
module tb_can_field_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_value = 1'b1;
    logic [6:0]  bit_index = '0;
    logic        frame_done, ext_frame, rtr, srr, crc_ok, ack_ok, sof_err, form_err;
    logic [1:0]  rsv;
    logic [3:0]  dlc;
    logic [10:0] base_id;
    logic [17:0] ext_id;
    logic [28:0] full_id;
    logic [63:0] data;
    logic [14:0] crc_rx;

    int checks = 0;
    int errors = 0;

    logic fb [0:127];
    int   last_pos;

    // expected values of the frame being sent
    logic        e_ext, e_rtr, e_srr, e_crc_ok, e_ack, e_sof, e_form;
    logic [1:0]  e_rsv;
    logic [3:0]  e_dlc;
    logic [10:0] e_base;
    logic [17:0] e_eid;
    logic [28:0] e_full;
    logic [63:0] e_data;
    logic [14:0] e_crc;

    always #10 clk = ~clk;

    can_field_parser dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
        .bit_index(bit_index), .frame_done(frame_done), .ext_frame(ext_frame),
        .rtr(rtr), .srr(srr), .rsv(rsv), .dlc(dlc), .base_id(base_id),
        .ext_id(ext_id), .full_id(full_id), .data(data), .crc_rx(crc_rx),
        .crc_ok(crc_ok), .ack_ok(ack_ok), .sof_err(sof_err), .form_err(form_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] ref_crc(input int upto);
        logic [14:0] c = '0;
        for (int i = 0; i <= upto; i++) begin
            logic m = fb[i] ^ c[14];
            c = {c[13:0], 1'b0};
            if (m) c = c ^ 15'h4599;
        end
        return c;
    endfunction

    // Build the destuffed bit image of one frame and its expected fields.
    task automatic build(input logic ext, input logic [10:0] bid, input logic [17:0] eid,
                         input logic rq, input logic sr, input logic r1, input logic r0,
                         input logic [3:0] dl, input logic [63:0] dat,
                         input logic flip, input logic nack, input logic cdel0,
                         input logic adel0, input logic sof1);
        int dend, nb;
        logic [14:0] c;
        for (int i = 0; i < 128; i++) fb[i] = 1'b1;
        fb[0] = sof1;
        for (int k = 0; k < 11; k++) fb[1 + k] = bid[10 - k];
        fb[12] = ext ? sr : rq;
        fb[13] = ext;
        if (!ext) begin
            fb[14] = r0;
            for (int k = 0; k < 4; k++) fb[15 + k] = dl[3 - k];
            dend = 18;
        end else begin
            for (int k = 0; k < 18; k++) fb[14 + k] = eid[17 - k];
            fb[32] = rq; fb[33] = r1; fb[34] = r0;
            for (int k = 0; k < 4; k++) fb[35 + k] = dl[3 - k];
            dend = 38;
        end
        nb = rq ? 0 : ((dl > 8) ? 8 : int'(dl));
        last_pos = dend + 8 * nb;
        for (int k = 0; k < nb; k++)
            for (int j = 0; j < 8; j++) fb[dend + 1 + 8 * k + j] = dat[8 * k + 7 - j];
        c = ref_crc(last_pos) ^ {14'd0, flip};
        for (int k = 0; k < 15; k++) fb[last_pos + 1 + k] = c[14 - k];
        fb[last_pos + 16] = ~cdel0;
        fb[last_pos + 17] = nack;
        fb[last_pos + 18] = ~adel0;
        e_ext = ext; e_rtr = rq; e_srr = ext & sr; e_rsv = {ext & r1, r0};
        e_dlc = dl; e_base = bid; e_eid = ext ? eid : 18'd0;
        e_full = ext ? {bid, eid} : {18'd0, bid};
        e_data = (nb == 8) ? dat : (dat & ((64'd1 << (8 * nb)) - 64'd1));
        e_crc = c; e_crc_ok = ~flip; e_ack = ~nack; e_sof = sof1; e_form = cdel0 | adel0;
    endtask

    // Offer one bit for a cycle, then an idle cycle with misleading inputs (R12).
    task automatic send_bit(input int i);
        @(negedge clk);
        bit_valid = 1'b1; bit_index = 7'(i); bit_value = fb[i];
        @(negedge clk);
        bit_valid = 1'b0; bit_index = 7'(i * 37 + 5); bit_value = ~fb[i];
    endtask

    task automatic run_frame(input string tag);
        logic [3:0] prev_dlc = dlc;
        for (int i = 0; i <= last_pos + 25; i++) begin
            send_bit(i);
            if (i == 20) begin
                chk({tag, " R11 no early done"}, 64'(frame_done), 64'd0);
                chk({tag, " R11 dlc held mid-frame"}, 64'(dlc), 64'(prev_dlc));
            end
        end
        chk({tag, " R11 done pulse"}, 64'(frame_done), 64'd1);
        chk({tag, " R2 base_id"}, 64'(base_id), 64'(e_base));
        chk({tag, " R2 R3 ext_frame"}, 64'(ext_frame), 64'(e_ext));
        chk({tag, " R3 ext_id"}, 64'(ext_id), 64'(e_eid));
        chk({tag, " R3 full_id"}, 64'(full_id), 64'(e_full));
        chk({tag, " R3 srr"}, 64'(srr), 64'(e_srr));
        chk({tag, " R2 rtr"}, 64'(rtr), 64'(e_rtr));
        chk({tag, " R2 rsv"}, 64'(rsv), 64'(e_rsv));
        chk({tag, " R5 dlc"}, 64'(dlc), 64'(e_dlc));
        chk({tag, e_rtr ? " R6 data" : " R4 data"}, data, e_data);
        chk({tag, " R7 crc_rx"}, 64'(crc_rx), 64'(e_crc));
        chk({tag, " R7 crc_ok"}, 64'(crc_ok), 64'(e_crc_ok));
        chk({tag, " R8 ack_ok"}, 64'(ack_ok), 64'(e_ack));
        chk({tag, " R9 form_err"}, 64'(form_err), 64'(e_form));
        chk({tag, " R10 sof_err"}, 64'(sof_err), 64'(e_sof));
        @(negedge clk);
        chk({tag, " R11 pulse ends"}, 64'(frame_done), 64'd0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset frame_done", 64'(frame_done), 64'd0);
        chk("R1 reset full_id", 64'(full_id), 64'd0);
        chk("R1 reset data", data, 64'd0);
        chk("R1 reset flags", {60'd0, crc_ok, ack_ok, sof_err, form_err}, 64'd0);
        chk("R1 reset dlc", 64'(dlc), 64'd0);

        // R2 R4 R5: every length code, 11-bit layout
        for (int d = 0; d < 16; d++) begin
            logic [3:0] dd = 4'(d);
            build(1'b0, 11'(d * 97 + 3), 18'd0, 1'b0, 1'b1, 1'b0, dd[0], dd,
                  64'h0123456789ABCDEF ^ (64'(d) * 64'h1111111111111111),
                  1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            run_frame("std");
        end
        // R3 R4 R5: every length code, 29-bit layout
        for (int d = 0; d < 16; d++) begin
            logic [3:0] dd = 4'(d);
            build(1'b1, 11'(d * 131 + 7), 18'(d * 5003 + 1), 1'b0, ~dd[2], dd[1], dd[0], dd,
                  64'hF0E1D2C3B4A59687 + 64'(d * 977), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            run_frame("ext");
        end
        // R6: remote frames in both layouts
        build(1'b0, 11'h5A3, 18'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF,
              1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("std remote");
        build(1'b1, 11'h7F0, 18'h2ABCD, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7, 64'hFFFF_FFFF_FFFF_FFFF,
              1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("ext remote");
        // R7 R8 R9 R10: single faults
        build(1'b0, 11'h123, 18'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 64'hBEEF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("crc flip");
        build(1'b1, 11'h321, 18'h00F0F, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 64'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_frame("nack");
        build(1'b0, 11'h0AA, 18'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 64'hCAFEF00D, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_frame("crc delim");
        build(1'b1, 11'h155, 18'h3FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_frame("ack delim");
        build(1'b0, 11'h400, 18'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 64'h1122334455667788, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_frame("sof");

        // R12: sweep every index with bit_valid low; nothing may change
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            bit_valid = 1'b0; bit_index = 7'(i); bit_value = i[0];
            @(negedge clk);
            chk("R12 idle no done", 64'(frame_done), 64'd0);
        end
        chk("R12 idle fields held", {dlc, sof_err, data[58:0]}, {4'd8, 1'b1, e_data[58:0]});
        finish_run();
    end
endmodule